// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block behaves as a 256-word by 16-bit serial memory on a select, serial-clock, serial-in and serial-out pin set. The select pin, the serial clock and the serial input all come from outside the chip. They are synchronised into the system clock, and the block then works on the rising edges of the serial clock that it detects there. Zeros that arrive after select rises are skipped. The first 1 is taken as the start bit. The two bits that follow it form the opcode: 10 is a read and 01 is a write. An 8-bit address then follows, MSB first.

A read puts a single 0 on the output on the edge that takes in the last address bit. The addressed word follows, MSB first. If the serial clock keeps running while select stays high, further words stream out from increasing addresses with no gap. A write takes in 16 data bits, MSB first. The word is stored when select falls after the last data bit, and that fall also starts a write cycle of fixed length. While the write cycle runs, the block ignores every command. Raising select during this time shows the state of the cycle on the output: low while the cycle is running, high once it has finished. This status stays on the output until the next start bit is accepted.

The pins carry one bit per serial clock and have no back-pressure: the external master paces every transfer. The high-impedance state of the output is given as a separate enable.

Top module: `serial_word_mem`

## Requirements
- R1: After reset every word reads as 0, and `ser_oe` is 0 whenever the synchronised select is low.
- R2: While select is high and no command has started, 0 bits are skipped. The first 1 sampled is the start bit, however many zeros come before it.
- R3: With opcode 10 (first opcode bit 1, second 0), the edge that samples address bit 0 drives `ser_out` to 0 (a dummy bit). The next 16 edges drive the addressed word, bit 15 first.
- R4: During a read, each further run of 16 edges with select high gives the word at the next address, with no dummy bit. The address wraps from 255 to 0.
- R5: With opcode 01, the 8 address bits and 16 data bits that follow are written to memory only when select falls after data bit 0 has been sampled. If select falls earlier, nothing is written.
- R6: A write that is committed makes the block busy for `WR_CYCLES` system clocks. While a status is pending and select is high, `ser_out` is 0 during the busy time and 1 after it. The status stays until the next start bit is accepted, after which `ser_out` returns to 0.
- R7: While busy, start bits are not accepted, so no read or write takes effect.
- R8: Opcodes 00 and 11 are ignored until select goes low: nothing is written and `ser_out` stays 0.
- R9: Select going low abandons any command that is partly received, and the next select-high period starts a fresh hunt for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 1 | Select, active high |
| ser_clk | input | 1 | Serial clock from the master |
| ser_in | input | 1 | Serial data into the block |
| ser_out | output | 1 | Serial data or ready/busy status |
| ser_oe | output | 1 | Output enable for ser_out; 0 means high impedance |

## Verification
The hardest case to reach is a complete command that arrives while the write cycle is still running. The whole command, including its 1 bits, has to fall inside the busy window, and the status on the output has to be observed before it is cleared. The bench makes the write cycle longer than a whole command takes to transfer. It then sends a full write to a second address right after committing the first, and reads both addresses back once the block is ready. Separate directed cases cover these:
- the busy-to-ready change on the output, while select is held high;
- clearing of the status by a later start bit;
- address wrap during a streaming read;
- aborted writes and ignored opcodes.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_OPC,
    ST_ADDR,
    ST_RD,
    ST_WD,
    ST_ARM,
    ST_IGN
  } swm_state_e;
endpackage

// File: rtl/swm_pin_sync.sv
module swm_pin_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[i] <= '0;
      else if (i == 0) stg[i] <= async_i;
      else             stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[STAGES-1];
  end

  assign sync_o = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev_q;
  assign fall_o = ~stg[STAGES-1] & prev_q;
endmodule

// File: rtl/swm_array.sv
module swm_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       q <= '0;
      else if (we && wa == AW'(g))      q <= wd;
    end
    assign words[g] = q;
  end

  assign rd = words[ra];
endmodule

// File: rtl/swm_engine.sv
module swm_engine
  import swm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          cs_fall,
  input  logic          sclk_rise,
  input  logic          sdi_s,
  input  logic          busy,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic          we,
  output logic [AW-1:0] wa,
  output logic [DW-1:0] wd,
  output logic          start_ok,
  output logic          sdo_bit
);
  localparam int MAXW  = (DW > AW) ? DW : AW;
  localparam int CNT_W = $clog2(MAXW);
  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(AW-1);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DW-1);

  swm_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             opc_hi;
  logic             rd_mode;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;

  assign start_ok = cs_s && sclk_rise && sdi_s && !busy && st == ST_HUNT;
  assign we       = cs_fall && st == ST_ARM;
  assign wa       = addr_q;
  assign wd       = data_q;
  assign rd_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_HUNT;
      cnt     <= '0;
      opc_hi  <= 1'b0;
      rd_mode <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      sdo_bit <= 1'b0;
    end else if (!cs_s) begin
      st      <= ST_HUNT;
      cnt     <= '0;
      sdo_bit <= 1'b0;
    end else if (sclk_rise) begin
      unique case (st)
        ST_HUNT: if (start_ok) begin st <= ST_OPC; cnt <= '0; end
        ST_OPC: begin
          if (cnt == '0) begin
            opc_hi <= sdi_s;
            cnt    <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (opc_hi != sdi_s) begin
              st      <= ST_ADDR;
              rd_mode <= opc_hi;
            end else begin
              st <= ST_IGN;
            end
          end
        end
        ST_ADDR: begin
          addr_q <= {addr_q[AW-2:0], sdi_s};
          if (cnt == LAST_A) begin
            cnt     <= '0;
            st      <= rd_mode ? ST_RD : ST_WD;
            sdo_bit <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RD: begin
          sdo_bit <= rd_word[LAST_D - cnt];
          if (cnt == LAST_D) begin
            cnt    <= '0;
            addr_q <= addr_q + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WD: begin
          data_q <= {data_q[DW-2:0], sdi_s};
          if (cnt == LAST_D) begin
            cnt <= '0;
            st  <= ST_ARM;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R2
  hunt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT && cs_s && sclk_rise && !sdi_s) |=> st == ST_HUNT);
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT && busy) |=> st == ST_HUNT);
  // R9
  cs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (st == ST_HUNT && !sdo_bit));
  // R3
  dummy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && cs_s && sclk_rise && cnt == LAST_A && rd_mode)
      |=> (st == ST_RD && !sdo_bit));
endmodule

// File: rtl/serial_word_mem.sv
module serial_word_mem #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int WR_CYCLES   = 200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel,
  input  logic ser_clk,
  input  logic ser_in,
  output logic ser_out,
  output logic ser_oe
);
  localparam int BW = $clog2(WR_CYCLES + 1);

  logic [2:0]    pin_s, pin_r, pin_f;
  logic          cs_s, cs_fall, sclk_rise, sdi_s;
  logic          we, start_ok, sdo_bit, busy, status_q;
  logic [AW-1:0] wa, ra;
  logic [DW-1:0] wd, rd;
  logic [BW-1:0] busy_cnt;

  swm_pin_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({chip_sel, ser_clk, ser_in}),
    .sync_o(pin_s), .rise_o(pin_r), .fall_o(pin_f)
  );

  assign cs_s      = pin_s[2];
  assign cs_fall   = pin_f[2];
  assign sclk_rise = pin_r[1];
  assign sdi_s     = pin_s[0];

  swm_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(we), .wa(wa), .wd(wd), .ra(ra), .rd(rd)
  );

  swm_engine #(.AW(AW), .DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sdi_s(sdi_s), .busy(busy), .rd_word(rd),
    .rd_addr(ra), .we(we), .wa(wa), .wd(wd), .start_ok(start_ok),
    .sdo_bit(sdo_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_cnt <= '0;
    else if (we)             busy_cnt <= BW'(WR_CYCLES);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end
  assign busy = busy_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status_q <= 1'b0;
    else if (we)       status_q <= 1'b1;
    else if (start_ok) status_q <= 1'b0;
  end

  assign ser_out = status_q ? ~busy : sdo_bit;
  assign ser_oe  = cs_s;

  // R5
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !busy);
  // R6
  busy_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (busy && status_q));
  // R1
  oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |-> !ser_oe);
endmodule

// File: tb/serial_word_mem_tb.sv
module serial_word_mem_tb;
  localparam int WR   = 2000;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chip_sel = 1'b0, ser_clk = 1'b0, ser_in = 1'b0;
  logic ser_out, ser_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] model [256];

  always #2 clk = ~clk;

  serial_word_mem #(.AW(8), .DW(16), .WR_CYCLES(WR), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .ser_clk(ser_clk),
    .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_bit(input logic [15:0] w, input int i);
    return w[15-i];
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input bit d, output bit q);
    ser_in = d;
    wait_clk(HALF); ser_clk = 1'b1;
    wait_clk(HALF); ser_clk = 1'b0;
    wait_clk(HALF); q = ser_out;
  endtask

  task automatic cs_up();   chip_sel = 1'b1; wait_clk(6); endtask
  task automatic cs_down(); chip_sel = 1'b0; wait_clk(6); endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    bit q;
    for (int i = n-1; i >= 0; i--) xfer(v[i], q);
  endtask

  // write; commit tells the bench whether the block should store it
  task automatic do_write(input logic [7:0] a, input logic [15:0] d,
                          input int zeros, input bit commit);
    cs_up();
    send_bits(0, zeros);
    send_bits(3'b101, 3);
    send_bits(a, 8);
    send_bits(d, 16);
    cs_down();
    if (commit) model[a] = d;
  endtask

  task automatic do_read(input logic [7:0] a, input int words, input int zeros, input string req);
    bit q;
    logic [7:0] ad;
    cs_up();
    send_bits(0, zeros);
    send_bits(3'b110, 3);
    send_bits(a >> 1, 7);
    xfer(a[0], q);
    chk(q == 1'b0, "R3 dummy", q, 0);
    ad = a;
    for (int w = 0; w < words; w++) begin
      logic [15:0] got;
      for (int i = 0; i < 16; i++) begin
        xfer(1'b0, q);
        got[15-i] = q;
        if (q != exp_bit(model[ad], i)) got[15-i] = q;
      end
      chk(got == model[ad], req, got, model[ad]);
      ad = ad + 8'd1;
    end
    cs_down();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    bit q;
    logic [7:0] ra;
    logic [15:0] rdat;
    void'($urandom(32'h5EED_0123));
    for (int i = 0; i < 256; i++) model[i] = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 reset state
    chk(ser_oe == 1'b0, "R1 oe after reset", ser_oe, 0);
    do_read(8'h00, 1, 0, "R1 reset word");
    chk(ser_oe == 1'b0, "R1 oe with select low", ser_oe, 0);

    // R5 R6 basic write with status watch
    do_write(8'h3C, 16'hA5C3, 0, 1'b1);
    cs_up();
    chk(ser_oe == 1'b1, "R1 oe with select high", ser_oe, 1);
    chk(ser_out == 1'b0, "R6 busy status", ser_out, 0);
    // R7 second write while busy, inside busy window
    cs_down();
    do_write(8'h3D, 16'h1234, 0, 1'b0);
    cs_up();
    chk(ser_out == 1'b0, "R6 still busy", ser_out, 0);
    wait_clk(WR);
    chk(ser_out == 1'b1, "R6 ready status", ser_out, 1);
    xfer(1'b0, q);
    chk(q == 1'b1, "R6 status held over zero", q, 1);
    xfer(1'b1, q);
    chk(q == 1'b0, "R6 status cleared by start", q, 0);
    send_bits(2'b11, 2);
    xfer(1'b1, q);
    chk(q == 1'b0, "R8 opcode 11 output", q, 0);
    cs_down();
    do_read(8'h3C, 2, 0, "R7 R5 readback after busy write");

    // R2 leading zeros
    do_read(8'h3C, 1, 7, "R2 zeros before start");

    // R5 aborted write
    cs_up();
    send_bits(3'b101, 3);
    send_bits(8'h3C, 8);
    send_bits(16'hFFFF, 10);
    cs_down();
    do_read(8'h3C, 1, 0, "R5 R9 abort leaves word");

    // R8 opcodes 11 and 00 followed by write-like bits
    cs_up();
    send_bits(3'b111, 3);
    send_bits(8'h3C, 8);
    send_bits(16'h0F0F, 16);
    cs_down();
    cs_up();
    send_bits(3'b100, 3);
    send_bits(8'h3C, 8);
    send_bits(16'h0F0F, 16);
    cs_down();
    wait_clk(WR + 20);
    do_read(8'h3C, 1, 0, "R8 ignored opcodes");

    // R4 wrap
    do_write(8'hFF, 16'hBEEF, 2, 1'b1);
    wait_clk(WR + 20);
    do_write(8'h00, 16'h7001, 0, 1'b1);
    wait_clk(WR + 20);
    do_read(8'hFE, 3, 0, "R4 stream with wrap");

    // R9 partial read then fresh command
    cs_up();
    send_bits(3'b110, 3);
    send_bits(8'h0A, 4);
    cs_down();
    do_read(8'hFF, 1, 1, "R9 fresh read after abort");

    // random writes and reads
    for (int k = 0; k < 14; k++) begin
      ra   = 8'($urandom_range(0, 255));
      rdat = 16'($urandom);
      do_write(ra, rdat, int'($urandom_range(0, 3)), 1'b1);
      wait_clk(WR + 20);
    end
    for (int k = 0; k < 6; k++) begin
      ra = 8'($urandom_range(0, 255));
      do_read(ra, 3, int'($urandom_range(0, 3)), "R3 R4 random read");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule